// File: doc/BRIEF.md
# Backup Supply Selector with Battery Seal

This controller decides which source feeds a memory supply rail: the main supply or a backup battery. It takes comparator flags as inputs: supply above the reset threshold, supply above the battery voltage, and battery present. It also takes the reset generator's state, the power-fail comparator result and the level sensed on the seal-request pin. It drives the two path switch selects and reports backup mode, seal state and an active-low early power-fail warning. Every asynchronous input passes through two flip-flops before any decision uses it. A source change always leaves one clock with neither switch closed.

A battery connected before any valid power-up stays sealed, so it never feeds the rail until the supply first rises above the reset threshold. The seal can be set again on purpose. While running from main power with reset released and a battery present, hold the seal-request pin low. When the supply then falls below the threshold, the battery is disconnected again. In backup, and for a write-protect interval after main power comes back, the warning output is held low. It also reports to the rest of the chip, through the backup flag, that the watchdog is off.

Top module: `backup_seal_ctrl`

## Requirements
- R1: While reset is active and just after it, both selects are 0, seal_active is 1, backup_mode is 0 and pf_warn_n is 0.
- R2: While seal_active is 1, bat_sel stays 0, including when only supply_gt_bat_a is 1.
- R3: A rise of supply_ok_a appears at the outputs on the third rising clock edge: main_sel goes to 1 and seal_active goes to 0.
- R4: With a battery present and main_sel at 1, the controller switches to the battery when supply_ok_a and supply_gt_bat_a are both 0. If only one of them is 0, nothing changes. On the third edge both selects are 0. On the fourth edge bat_sel and backup_mode are 1.
- R5: With bat_here_a at 0, a falling supply leaves main_sel at 1.
- R6: In backup, the return condition (supply_ok_a or supply_gt_bat_a at 1) must hold for SETTLE_CYCLES synchronized cycles in a row. Shorter bursts leave bat_sel at 1.
- R7: After the return condition has held long enough, bat_sel drops and one clock later main_sel rises. backup_mode clears with bat_sel.
- R8: main_sel and bat_sel are never 1 together, and neither rises in the cycle right after the other was 1.
- R9: In main mode, with reset_on_a at 0, seal_req_n_a at 0 and a battery present, the next fall of supply_ok_a sets seal_active to 1. Both selects go to 0 and backup mode is not entered.
- R10: Once set, seal_active stays 1 until supply_ok_a rises again.
- R11: pf_warn_n is 0 whenever main_sel is 0, including in backup.
- R12: Each entry into main mode holds pf_warn_n at 0 for WP_CYCLES edges. After that, pf_warn_n is the inverse of the synchronized pf_below_a (1 means the monitored input is below its threshold), with two edges of delay. A comparator input tied to 0 therefore gives a steady 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_a | input | 1 | Supply above reset threshold (async) |
| supply_gt_bat_a | input | 1 | Supply above battery voltage (async) |
| bat_here_a | input | 1 | Battery present (async) |
| reset_on_a | input | 1 | Reset generator currently asserting reset |
| pf_below_a | input | 1 | Power-fail comparator: monitored input below threshold |
| seal_req_n_a | input | 1 | Sensed level of the seal-request pin, low requests sealing |
| main_sel | output | 1 | Close main supply path |
| bat_sel | output | 1 | Close battery path |
| backup_mode | output | 1 | Running from battery; watchdog reported disabled |
| seal_active | output | 1 | Battery sealed off from the rail |
| pf_warn_n | output | 1 | Early power-fail warning, active low |

## Verification
The assertions assume every input level stays stable long enough to pass through the two-stage synchronizer. They also assume the battery flag does not change during the single break-before-make cycle. The bench changes inputs only on falling clock edges and holds each level for several cycles. In the hysteresis test, short bursts are still at least one full clock long, so each one reaches the synchronized stage as a clean pulse and is not lost as a sub-cycle glitch.

// File: rtl/backup_seal_ctrl.sv
module backup_seal_ctrl #(
  parameter int SETTLE_CYCLES = 16,
  parameter int WP_CYCLES     = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_a,
  input  logic supply_gt_bat_a,
  input  logic bat_here_a,
  input  logic reset_on_a,
  input  logic pf_below_a,
  input  logic seal_req_n_a,
  output logic main_sel,
  output logic bat_sel,
  output logic backup_mode,
  output logic seal_active,
  output logic pf_warn_n
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int WW = $clog2(WP_CYCLES + 1);

  typedef enum logic [2:0] {S_OFF, S_MAIN, S_TO_BAT, S_BAT, S_TO_MAIN} st_t;

  logic [5:0] s1, s2;
  st_t st, nxt;
  logic [SW-1:0] settle;
  logic [WW-1:0] wp;
  logic pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {seal_req_n_a, pf_below_a, reset_on_a, bat_here_a, supply_gt_bat_a, supply_ok_a};
      s2 <= s1;
    end

  wire ok     = s2[0];
  wire gtb    = s2[1];
  wire bat    = s2[2];
  wire rst_on = s2[3];
  wire pfb    = s2[4];
  wire req_n  = s2[5];

  wire drop    = bat && !ok && !gtb;
  wire back    = ok || gtb;
  wire seal_go = (st == S_MAIN) && pend && !ok;

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:     if (ok) nxt = S_MAIN;
      S_MAIN:    if (seal_go) nxt = S_OFF;
                 else if (drop) nxt = S_TO_BAT;
      S_TO_BAT:  nxt = S_BAT;
      S_BAT:     if (back && settle == SW'(SETTLE_CYCLES - 1)) nxt = S_TO_MAIN;
      S_TO_MAIN: nxt = S_MAIN;
      default:   nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= S_OFF;
      settle      <= '0;
      wp          <= '0;
      pend        <= 1'b0;
      seal_active <= 1'b1;
    end else begin
      st <= nxt;

      if (st != S_BAT || !back || nxt != S_BAT) settle <= '0;
      else                                        settle <= settle + 1'b1;

      if (nxt == S_MAIN && st != S_MAIN) wp <= WW'(WP_CYCLES);
      else if (st == S_MAIN && wp != '0) wp <= wp - 1'b1;

      if (seal_go || !bat)                               pend <= 1'b0;
      else if (st == S_MAIN && ok && !rst_on && !req_n)  pend <= 1'b1;

      if (seal_go) seal_active <= 1'b1;
      else if (ok) seal_active <= 1'b0;
    end

  assign main_sel    = (st == S_MAIN);
  assign bat_sel     = (st == S_BAT);
  assign backup_mode = (st == S_BAT);
  assign pf_warn_n   = main_sel && (wp == '0) && !pfb;

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_sel && bat_sel));
  assert_gap_bat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_sel) |-> !$past(main_sel));
  assert_gap_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sel) |-> !$past(bat_sel));
  assert_sealed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seal_active |-> !bat_sel);
  assert_seal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seal_active && !ok) |=> seal_active);
  assert_pfo_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !main_sel |-> !pf_warn_n);
  assert_wp_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sel) |-> !pf_warn_n);
endmodule

// File: tb/sim_backup_seal_ctrl.sv
`timescale 1ns/1ps
module sim_backup_seal_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ok = 0, gtb = 0, bat = 1, rst_on = 1, pfb = 0, req_n = 1;
  logic main_sel, bat_sel, backup_mode, seal_active, pf_warn_n;
  int checks = 0, errors = 0, overlap = 0;
  bit done = 0;

  always #2 clk = ~clk;

  backup_seal_ctrl #(.SETTLE_CYCLES(4), .WP_CYCLES(6)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_a(ok), .supply_gt_bat_a(gtb),
    .bat_here_a(bat), .reset_on_a(rst_on), .pf_below_a(pfb), .seal_req_n_a(req_n),
    .main_sel(main_sel), .bat_sel(bat_sel), .backup_mode(backup_mode),
    .seal_active(seal_active), .pf_warn_n(pf_warn_n));

  always @(negedge clk) if (main_sel && bat_sel) overlap++;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    tick(3); rst_n = 1'b1;
    chk("R1 main_sel", main_sel, 0); chk("R1 bat_sel", bat_sel, 0);
    chk("R1 seal", seal_active, 1); chk("R1 backup", backup_mode, 0);
    chk("R1 pfo", pf_warn_n, 0);
  endtask

  task automatic t_sealed;
    gtb = 1; tick(8);
    chk("R2 bat_sel sealed", bat_sel, 0); chk("R2 main_sel", main_sel, 0);
    chk("R2 seal", seal_active, 1);
  endtask

  task automatic t_powerup;
    ok = 1; tick(2);
    chk("R3 latency main", main_sel, 0); chk("R3 latency seal", seal_active, 1);
    tick(1);
    chk("R3 main_sel", main_sel, 1); chk("R3 seal clear", seal_active, 0);
    chk("R12 pfo held", pf_warn_n, 0);
    rst_on = 0;
    tick(5); chk("R12 pfo still held", pf_warn_n, 0);
    tick(1); chk("R12 pfo released", pf_warn_n, 1);
  endtask

  task automatic t_pfo_follow;
    pfb = 1; tick(1); chk("R12 pfo delay", pf_warn_n, 1);
    tick(1); chk("R12 pfo follows low", pf_warn_n, 0);
    pfb = 0; tick(2); chk("R12 pfo follows high", pf_warn_n, 1);
  endtask

  task automatic t_partial;
    ok = 0; gtb = 1; tick(6);
    chk("R4 one flag low keeps main", main_sel, 1); chk("R4 no bat", bat_sel, 0);
  endtask

  task automatic t_nobat;
    bat = 0; gtb = 0; tick(6);
    chk("R5 no battery keeps main", main_sel, 1); chk("R5 bat_sel", bat_sel, 0);
  endtask

  task automatic t_switch;
    bat = 1; tick(3);
    chk("R4 gap main", main_sel, 0); chk("R4 gap bat", bat_sel, 0);
    tick(1);
    chk("R4 bat_sel", bat_sel, 1); chk("R4 backup", backup_mode, 1);
    chk("R11 pfo forced", pf_warn_n, 0);
  endtask

  task automatic t_glitch;
    ok = 1; tick(2); ok = 0; tick(8);
    chk("R6 short burst ignored", bat_sel, 1);
  endtask

  task automatic t_return;
    ok = 1; tick(5);
    chk("R6 still waiting", bat_sel, 1);
    tick(1);
    chk("R7 gap bat", bat_sel, 0); chk("R7 gap main", main_sel, 0);
    chk("R7 backup clear", backup_mode, 0);
    tick(1);
    chk("R7 main_sel", main_sel, 1); chk("R12 pfo held after return", pf_warn_n, 0);
    tick(6);
    chk("R12 pfo after interval", pf_warn_n, 1);
  endtask

  task automatic t_seal;
    req_n = 0; tick(4);
    ok = 0; gtb = 0; tick(3);
    chk("R9 seal set", seal_active, 1); chk("R9 main off", main_sel, 0);
    chk("R9 bat off", bat_sel, 0); chk("R9 no backup", backup_mode, 0);
    tick(10);
    chk("R10 seal held", seal_active, 1); chk("R10 bat off", bat_sel, 0);
    chk("R11 pfo off", pf_warn_n, 0);
    gtb = 1; tick(6);
    chk("R10 seal held above bat", seal_active, 1); chk("R2 still unpowered", main_sel, 0);
    req_n = 1; ok = 1; tick(2);
    chk("R10 seal until sync", seal_active, 1);
    tick(1);
    chk("R10 seal cleared", seal_active, 0); chk("R10 main back", main_sel, 1);
  endtask

  initial begin
    t_reset; t_sealed; t_powerup; t_pfo_follow; t_partial;
    t_nobat; t_switch; t_glitch; t_return; t_seal;
    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R8 overlap cycles actual=%0d expected=0", overlap);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule